// File: doc/BRIEF.md
# Majority-Voted Redundant Memory

This block is a small word-addressed memory that keeps every word in three separate copies. Any single copy may be corrupted by a bit upset without the requester ever seeing a wrong value. A requester presents an operation (read or write), an address and write data. The block answers with a one-cycle `done` pulse, read data and a flag showing that the copies disagreed and the answer was repaired by voting.

A write stores the same word into all three copies in the cycle it is accepted. A read fetches all three copies. It votes each bit separately and returns the majority word. If the requester asked for scrubbing and the copies disagreed, the block spends one extra cycle writing the voted word back into every copy. The repair then persists and `done` arrives one cycle later. A test port flips one chosen bit of one chosen copy, so that upsets can be produced on demand.

Control is a four-state machine. In IDLE the block accepts requests: a write moves it to WACK and a read moves it to VOTE. WACK signals completion of a write and returns to IDLE. VOTE presents the voted word and returns to IDLE, except when scrubbing was requested and the copies disagree, in which case it moves to SCRUB. SCRUB writes the repair and signals completion, then returns to IDLE.

Top module: `triple_vote_mem`

## Requirements
- R1: After reset `done` and `corrected` are low, and every address reads back as zero with `corrected` low.
- R2: A write accepted in IDLE stores the data into all three copies at the accepting edge. `done` is high for exactly the following cycle with `corrected` low.
- R3: A read accepted in IDLE yields `done` one cycle later, unless R6 applies. `rd_data` carries the bitwise majority of the three copies, so two copies corrupted in the same bit return the corrupted bit.
- R4: `corrected` is high only together with `done` on a read. It is high exactly when the three copies of the word read differ in at least one bit.
- R5: Any corruption confined to a single copy, in any number of its bits, reads back as the originally written word.
- R6: When `scrub_en` is high at the accepting edge of a read whose copies disagree, `done` comes two cycles after acceptance with the voted word and `corrected` high. All three copies are rewritten with that word, so the next read of the address reports `corrected` low.
- R7: Without scrubbing a read changes no copy: a repeated read of a corrupted word again reports `corrected` high with the same voted data.
- R8: `inject_en` flips bit `inject_bit` of copy `inject_copy` (0, 1 or 2) at `inject_addr` at the next edge. It is honoured only in IDLE with `req_valid` low. Copy index 3, or an injection during a request or a busy cycle, has no effect.
- R9: `req_valid` presented while the block is not in IDLE is ignored: no copy is written and no extra `done` follows.
- R10: `done` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; clears all copies |
| req_valid | input | 1 | Request present (accepted only in IDLE) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| scrub_en | input | 1 | Write the voted word back on a corrected read |
| inject_en | input | 1 | Test: flip one stored bit |
| inject_copy | input | 2 | Test: copy index 0..2 (3 is ignored) |
| inject_addr | input | ADDR_W | Test: address of the bit to flip |
| inject_bit | input | $clog2(DATA_W) | Test: bit index to flip |
| done | output | 1 | Operation complete, one-cycle pulse |
| rd_data | output | DATA_W | Voted read data, valid with `done` on a read |
| corrected | output | 1 | Copies disagreed for the word read |

## Verification
The bench builds the block with its defaults of 16-bit words and 16 addresses. This small address space lets random upsets often land on the same word in different copies. That brings two-copy corruption into reach, where the majority itself flips a bit, alongside the single-copy cases that voting must mask. Because a 4-bit bit index covers every data bit, random injection and directed flips reach both end bits of the word. Scrubbed and unscrubbed reads of the same corrupted word are compared against three shadow copies kept in the bench.

// File: rtl/tvm_pkg.sv
package tvm_pkg;

    localparam int COPIES = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WACK,
        ST_VOTE,
        ST_SCRUB
    } vstate_t;

endpackage

// File: rtl/tvm_bank.sv
module tvm_bank #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [ADDR_W-1:0]         waddr,
    input  logic [DATA_W-1:0]         wdata,
    input  logic                      flip_en,
    input  logic [ADDR_W-1:0]         flip_addr,
    input  logic [$clog2(DATA_W)-1:0] flip_bit,
    input  logic                      rd_en,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [DATA_W-1:0]         rd_data
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic [DATA_W-1:0] store_q [DEPTH];
    logic [DATA_W-1:0] rd_q;

    // Normal writes take priority over a fault flip in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                store_q[i] <= '0;
            end
        end else if (we) begin
            store_q[waddr] <= wdata;
        end else if (flip_en) begin
            store_q[flip_addr] <= store_q[flip_addr] ^ (ONE << flip_bit);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= store_q[rd_addr];
        end
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/tvm_voter.sv
module tvm_voter #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] copy_a,
    input  logic [DATA_W-1:0] copy_b,
    input  logic [DATA_W-1:0] copy_c,
    output logic [DATA_W-1:0] voted,
    output logic              mismatch
);
    logic [DATA_W-1:0] differ;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign voted[i]  = (copy_a[i] & copy_b[i]) |
                           (copy_a[i] & copy_c[i]) |
                           (copy_b[i] & copy_c[i]);
        assign differ[i] = (copy_a[i] ^ copy_b[i]) | (copy_a[i] ^ copy_c[i]);
    end

    assign mismatch = |differ;

endmodule

// File: rtl/tvm_ctrl.sv
module tvm_ctrl
    import tvm_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              scrub_en,
    input  logic [DATA_W-1:0] voted,
    input  logic              mismatch,
    output logic              bank_we,
    output logic [ADDR_W-1:0] bank_waddr,
    output logic [DATA_W-1:0] bank_wdata,
    output logic              bank_rd_en,
    output logic [ADDR_W-1:0] bank_rd_addr,
    output logic              idle,
    output logic              in_scrub,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              corrected
);
    vstate_t           state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic              scrub_q;
    logic [DATA_W-1:0] fix_q;
    logic              accept;

    assign accept = req_valid && (state_q == ST_IDLE);

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request context and scrub word
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            scrub_q <= 1'b0;
            fix_q   <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                scrub_q <= scrub_en;
            end
            if (state_q == ST_VOTE) begin
                fix_q <= voted;
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = req_write ? ST_WACK : ST_VOTE;
                end
            end
            ST_WACK:  state_d = ST_IDLE;
            ST_VOTE:  state_d = (mismatch && scrub_q) ? ST_SCRUB : ST_IDLE;
            ST_SCRUB: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        bank_we      = 1'b0;
        bank_waddr   = req_addr;
        bank_wdata   = req_wdata;
        bank_rd_en   = 1'b0;
        bank_rd_addr = req_addr;
        idle         = 1'b0;
        in_scrub     = 1'b0;
        done         = 1'b0;
        rd_data      = '0;
        corrected    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                idle       = 1'b1;
                bank_we    = accept && req_write;
                bank_rd_en = accept && !req_write;
            end
            ST_WACK: begin
                done = 1'b1;
            end
            ST_VOTE: begin
                if (!(mismatch && scrub_q)) begin
                    done      = 1'b1;
                    rd_data   = voted;
                    corrected = mismatch;
                end
            end
            ST_SCRUB: begin
                in_scrub   = 1'b1;
                bank_we    = 1'b1;
                bank_waddr = addr_q;
                bank_wdata = fix_q;
                done       = 1'b1;
                rd_data    = fix_q;
                corrected  = 1'b1;
            end
            default: begin
                idle = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/triple_vote_mem.sv
module triple_vote_mem
    import tvm_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [DATA_W-1:0]         req_wdata,
    input  logic                      scrub_en,
    input  logic                      inject_en,
    input  logic [1:0]                inject_copy,
    input  logic [ADDR_W-1:0]         inject_addr,
    input  logic [$clog2(DATA_W)-1:0] inject_bit,
    output logic                      done,
    output logic [DATA_W-1:0]         rd_data,
    output logic                      corrected
);
    logic                 ctl_we;
    logic [ADDR_W-1:0]    ctl_waddr;
    logic [DATA_W-1:0]    ctl_wdata;
    logic                 ctl_rd_en;
    logic [ADDR_W-1:0]    ctl_rd_addr;
    logic                 ctrl_idle;
    logic                 ctrl_scrub;
    logic [DATA_W-1:0]    voted;
    logic                 mismatch;
    logic                 inj_ok;
    logic [COPIES-1:0]    bank_we;
    logic [COPIES-1:0]    flip_en;
    logic [DATA_W-1:0]    copy_q [COPIES];

    assign inj_ok = inject_en && ctrl_idle && !req_valid;

    for (genvar i = 0; i < COPIES; i++) begin : g_copy
        assign bank_we[i] = ctl_we;
        assign flip_en[i] = inj_ok && (inject_copy == 2'(i));

        tvm_bank #(
            .DATA_W(DATA_W),
            .ADDR_W(ADDR_W)
        ) u_bank (
            .clk      (clk),
            .rst      (rst),
            .we       (bank_we[i]),
            .waddr    (ctl_waddr),
            .wdata    (ctl_wdata),
            .flip_en  (flip_en[i]),
            .flip_addr(inject_addr),
            .flip_bit (inject_bit),
            .rd_en    (ctl_rd_en),
            .rd_addr  (ctl_rd_addr),
            .rd_data  (copy_q[i])
        );
    end

    tvm_voter #(
        .DATA_W(DATA_W)
    ) u_voter (
        .copy_a  (copy_q[0]),
        .copy_b  (copy_q[1]),
        .copy_c  (copy_q[2]),
        .voted   (voted),
        .mismatch(mismatch)
    );

    tvm_ctrl #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .scrub_en    (scrub_en),
        .voted       (voted),
        .mismatch    (mismatch),
        .bank_we     (ctl_we),
        .bank_waddr  (ctl_waddr),
        .bank_wdata  (ctl_wdata),
        .bank_rd_en  (ctl_rd_en),
        .bank_rd_addr(ctl_rd_addr),
        .idle        (ctrl_idle),
        .in_scrub    (ctrl_scrub),
        .done        (done),
        .rd_data     (rd_data),
        .corrected   (corrected)
    );

endmodule

// File: rtl/tvm_checks.sv
module tvm_checks
    import tvm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic              scrub_en,
    input logic              idle,
    input logic              in_scrub,
    input logic [COPIES-1:0] bank_we,
    input logic              done,
    input logic              corrected
);
    assert_write_all_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && idle) |-> (&bank_we));

    assert_write_done_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && idle) |=> (done && !corrected));

    assert_read_done_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && idle && !scrub_en) |=> done);

    assert_corr_with_done_R4: assert property (@(posedge clk) disable iff (rst)
        corrected |-> done);

    assert_scrub_write_R6: assert property (@(posedge clk) disable iff (rst)
        in_scrub |-> ((&bank_we) && done && corrected));

    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (rst)
        (!idle && !in_scrub) |-> (bank_we == '0));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

bind triple_vote_mem tvm_checks u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_write(req_write),
    .scrub_en (scrub_en),
    .idle     (ctrl_idle),
    .in_scrub (ctrl_scrub),
    .bank_we  (bank_we),
    .done     (done),
    .corrected(corrected)
);

// File: tb/triple_vote_mem_test.sv
module triple_vote_mem_test;
    localparam int DW    = 16;
    localparam int AW    = 4;
    localparam int BW    = $clog2(DW);
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          scrub_en = 1'b0;
    logic          inject_en = 1'b0;
    logic [1:0]    inject_copy = '0;
    logic [AW-1:0] inject_addr = '0;
    logic [BW-1:0] inject_bit = '0;
    logic          done;
    logic [DW-1:0] rd_data;
    logic          corrected;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [DW-1:0] mdl [3][DEPTH];

    always #2 clk = ~clk;

    triple_vote_mem #(.DATA_W(DW), .ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .scrub_en(scrub_en),
        .inject_en(inject_en), .inject_copy(inject_copy),
        .inject_addr(inject_addr), .inject_bit(inject_bit),
        .done(done), .rd_data(rd_data), .corrected(corrected)
    );

    function automatic logic [DW-1:0] maj3(logic [DW-1:0] a, logic [DW-1:0] b, logic [DW-1:0] c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic op_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        chk(done === 1'b1 && corrected === 1'b0, "R2 write done", {30'd0, done, corrected}, 32'h2);
        for (int c = 0; c < 3; c++) mdl[c][a] = d;
    endtask

    task automatic op_inject(input logic [1:0] c, input logic [AW-1:0] a, input logic [BW-1:0] b);
        @(negedge clk);
        inject_en = 1'b1; inject_copy = c; inject_addr = a; inject_bit = b;
        @(posedge clk);
        @(negedge clk);
        inject_en = 1'b0;
        if (c < 2'd3) mdl[c][a][b] = ~mdl[c][a][b];
    endtask

    task automatic op_read(input logic [AW-1:0] a, input bit scr, input string tag,
                           output logic [DW-1:0] dout, output logic cout);
        logic [DW-1:0] exp_d;
        logic          exp_c;
        int            lat;
        exp_d = maj3(mdl[0][a], mdl[1][a], mdl[2][a]);
        exp_c = (mdl[0][a] != mdl[1][a]) || (mdl[0][a] != mdl[2][a]);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; scrub_en = scr;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; scrub_en = 1'b0;
        lat = 1;
        while (done !== 1'b1 && lat < 4) begin
            @(negedge clk);
            lat++;
        end
        dout = rd_data;
        cout = corrected;
        chk(dout === exp_d, {tag, " data"}, 32'(dout), 32'(exp_d));
        chk(cout === exp_c, {tag, " corrected"}, 32'(cout), 32'(exp_c));
        chk(lat == ((scr && exp_c) ? 2 : 1), {tag, " latency"}, 32'(lat), (scr && exp_c) ? 32'd2 : 32'd1);
        if (scr && exp_c) begin
            for (int c = 0; c < 3; c++) mdl[c][a] = exp_d;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        logic          cr;
        for (int c = 0; c < 3; c++)
            for (int a = 0; a < DEPTH; a++) mdl[c][a] = '0;
        void'($urandom(32'h5eed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(done === 1'b0 && corrected === 1'b0, "R1 idle outputs", {30'd0, done, corrected}, 32'h0);

        // R1: all addresses read zero after reset
        for (int a = 0; a < DEPTH; a++) op_read(AW'(a), 1'b0, "R1 reset read", d, cr);

        // R2/R3: fill with patterns
        for (int a = 0; a < DEPTH; a++) op_write(AW'(a), DW'(16'hA5C3 ^ (a * 16'h1111)));
        op_read(4'd3, 1'b0, "R3 clean read", d, cr);

        // R5: single-copy corruption in several bits, each copy in turn
        for (int c = 0; c < 3; c++) begin
            op_write(4'd5, 16'h8001);
            op_inject(2'(c), 4'd5, 4'd0);
            op_inject(2'(c), 4'd5, 4'd15);
            op_inject(2'(c), 4'd5, 4'd7);
            op_read(4'd5, 1'b0, "R5 single copy", d, cr);
            chk(d === 16'h8001, "R5 original word", 32'(d), 32'h8001);
        end

        // R7: no scrub keeps corruption
        op_write(4'd6, 16'h1234);
        op_inject(2'd1, 4'd6, 4'd4);
        op_read(4'd6, 1'b0, "R7 first read", d, cr);
        op_read(4'd6, 1'b0, "R7 repeat read", d, cr);
        chk(cr === 1'b1, "R7 still corrected", 32'(cr), 32'h1);

        // R6: scrub repairs
        op_read(4'd6, 1'b1, "R6 scrub read", d, cr);
        chk(d === 16'h1234, "R6 scrub data", 32'(d), 32'h1234);
        op_read(4'd6, 1'b1, "R6 after scrub", d, cr);
        chk(cr === 1'b0, "R6 repaired", 32'(cr), 32'h0);

        // R3/R4: two copies flipped in the same bit win the vote
        op_write(4'd7, 16'h00F0);
        op_inject(2'd0, 4'd7, 4'd1);
        op_inject(2'd2, 4'd7, 4'd1);
        op_read(4'd7, 1'b0, "R3 two-copy", d, cr);
        chk(d === 16'h00F2, "R3 majority flips", 32'(d), 32'h00F2);
        op_write(4'd7, 16'h00F0);

        // R8: copy index 3 ignored
        op_inject(2'd3, 4'd8, 4'd2);
        op_read(4'd8, 1'b0, "R8 copy3 ignored", d, cr);
        chk(cr === 1'b0, "R8 copy3 no flip", 32'(cr), 32'h0);

        // R8: injection with a request in the same cycle ignored
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 4'd9; req_wdata = 16'hBEEF;
        inject_en = 1'b1; inject_copy = 2'd0; inject_addr = 4'd9; inject_bit = 4'd3;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; inject_en = 1'b0;
        for (int c = 0; c < 3; c++) mdl[c][9] = 16'hBEEF;
        op_read(4'd9, 1'b0, "R8 inject during request", d, cr);

        // R9/R10: request while busy is ignored
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 4'd2;
        @(posedge clk);
        @(negedge clk);
        chk(done === 1'b1, "R3 busy test read done", 32'(done), 32'h1);
        req_write = 1'b1; req_addr = 4'd10; req_wdata = 16'hDEAD;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        chk(done === 1'b0, "R10 no second done", 32'(done), 32'h0);
        op_read(4'd10, 1'b0, "R9 busy write ignored", d, cr);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            int unsigned r;
            logic [AW-1:0] a;
            r = $urandom_range(0, 9);
            a = AW'($urandom_range(0, DEPTH - 1));
            if (r < 3) op_write(a, DW'($urandom()));
            else if (r < 6) op_inject(2'($urandom_range(0, 3)), a, BW'($urandom_range(0, DW - 1)));
            else op_read(a, bit'($urandom_range(0, 1)), "R4 random read", d, cr);
        end

        finished = 1'b1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule